// File: doc/BRIEF.md
# SPI Interrupt Status Controller

This block gathers four single-cycle event indications from an SPI controller (transmit done, receive ready, receive overflow, transmit underrun) and holds each one in a sticky raw status bit. Software reads the raw bits, or a masked view in which each bit is gated by its own enable. It clears a bit by writing a one to it in a clear register. A single interrupt line is high whenever any masked bit is set.

Register access uses a simple memory-mapped bus with 32-bit words. Every access is one cycle: an access valid strobe, a write flag, a byte address and write data. Read data is combinational from the address and the current state, and is zero whenever no read is in progress. The enable bits sit in a control word shared with other controller settings. Their order there differs from the status bit order, so the block keeps a fixed mapping between the two. Control bits outside the enable field are not stored and read as zero.

Top module: `spi_irq_top`

## Requirements
- R1: After reset all raw status bits and all enables are zero, the interrupt output is low, and a read of any offset returns zero.
- R2: An event pulse sampled at a rising clock edge sets its raw status bit from that edge onward. The bit stays set until it is cleared. Status bit positions are: bit 0 transmit done, bit 1 receive ready, bit 2 receive overflow, bit 3 transmit underrun. The raw view reads at offset 0x24 with bits 31:4 zero.
- R3: A write to offset 0x0c clears every raw bit whose write-data bit (3:0) is 1. Bits written as 0 keep their value. A read of 0x0c returns zero.
- R4: If an event and a clear hit the same bit at the same edge, the bit is set after that edge.
- R5: A write to offset 0x00 loads the enables from write-data bits 7:4: bit 4 enables receive ready, bit 5 enables transmit done, bit 6 enables receive overflow, bit 7 enables transmit underrun. A read of 0x00 returns the enables in the same positions, with all other bits zero.
- R6: A read of offset 0x20 returns each raw bit ANDed with its enable, in status bit positions 3:0, with bits 31:4 zero.
- R7: The interrupt output is high exactly when at least one masked bit is set. It follows an enable or clear write from the edge that samples that write.
- R8: Raw bits latch events whatever the enables hold, so enabling a bit later raises the interrupt for an event that is already pending.
- R9: Writes to offsets 0x20, 0x24 or any undecoded offset change no state, and reads of undecoded offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busEn | input | 1 | Bus access valid for this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational, zero when no read |
| evtTxDone | input | 1 | Transmit done event pulse |
| evtRxReady | input | 1 | Receive ready event pulse |
| evtRxOverflow | input | 1 | Receive overflow event pulse |
| evtTxUnderrun | input | 1 | Transmit underrun event pulse |
| irq | output | 1 | Interrupt request, OR of masked bits |

## Verification
Events, clear writes and control writes are sampled at a rising edge. Their effect shows on the raw, masked and control views, and on the interrupt line, directly after that same edge, with no further register stage. Read data depends only on the address presented and the current state, so it is due in the cycle of the read. The bench drives inputs on the falling edge and compares read data and the interrupt against its model one time unit later. It advances the model at the rising edge, so every comparison uses the state produced by the previous edge. The collision case (an event and a clear on the same bit) and the mapping between the enable bits and the status bits are driven on purpose in their own phases, and again in a long random phase.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

  // number of event sources; the bit encoding is fixed by the requirements
  localparam int SRC_N = 4;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CTRL = 2'd1,
    RD_MASK = 2'd2,
    RD_RAW  = 2'd3
  } rdSel_e;

  // strobes from decode control to the datapath
  typedef struct packed {
    logic   ctrlWr;
    logic   clrWr;
    rdSel_e rdSel;
  } regStrobe_t;

  // control-word bit that holds the enable for status index idx
  function automatic int enPos(input int idx, input int base);
    case (idx)
      0:       return base + 1;  // transmit done enable
      1:       return base;      // receive ready enable
      default: return base + idx;
    endcase
  endfunction

endpackage

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFF_CTRL = 8'h00,
  parameter logic [ADDR_W-1:0] OFF_CLR  = 8'h0c,
  parameter logic [ADDR_W-1:0] OFF_MASK = 8'h20,
  parameter logic [ADDR_W-1:0] OFF_RAW  = 8'h24
) (
  input  logic              busEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strb
);

  logic hitCtrl, hitClr, hitMask, hitRaw;
  logic isWrite, isRead;

  assign hitCtrl = (busAddr == OFF_CTRL);
  assign hitClr  = (busAddr == OFF_CLR);
  assign hitMask = (busAddr == OFF_MASK);
  assign hitRaw  = (busAddr == OFF_RAW);

  assign isWrite = busEn &  busWe;
  assign isRead  = busEn & ~busWe;

  always_comb begin
    strb.ctrlWr = isWrite & hitCtrl;
    strb.clrWr  = isWrite & hitClr;
    strb.rdSel  = RD_NONE;
    if (isRead) begin
      if (hitCtrl)      strb.rdSel = RD_CTRL;
      else if (hitMask) strb.rdSel = RD_MASK;
      else if (hitRaw)  strb.rdSel = RD_RAW;
    end
  end

endmodule

// File: rtl/spi_irq_datapath.sv
module spi_irq_datapath
  import spi_irq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int EN_BASE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SRC_N-1:0]  evtVec,
  output logic [SRC_N-1:0]  rawStat,
  output logic [SRC_N-1:0]  enStat,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  localparam int EN_TOP = EN_BASE + SRC_N - 1;

  logic [SRC_N-1:0]  maskStat;
  logic [DATA_W-1:0] ctrlView;

  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    // sticky raw bit: an event outranks a clear at the same edge
    always_ff @(posedge clk) begin
      if (rst)                         rawStat[i] <= 1'b0;
      else if (evtVec[i])              rawStat[i] <= 1'b1;
      else if (strb.clrWr && wdata[i]) rawStat[i] <= 1'b0;
    end

    // enables are held in status order, loaded from their control positions
    always_ff @(posedge clk) begin
      if (rst)              enStat[i] <= 1'b0;
      else if (strb.ctrlWr) enStat[i] <= wdata[enPos(i, EN_BASE)];
    end
  end

  assign maskStat = rawStat & enStat;
  assign irq      = |maskStat;

  always_comb begin
    ctrlView = '0;
    for (int i = 0; i < SRC_N; i++) ctrlView[enPos(i, EN_BASE)] = enStat[i];
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_CTRL: rdata = ctrlView;
      RD_MASK: rdata = {{(DATA_W-SRC_N){1'b0}}, maskStat};
      RD_RAW:  rdata = {{(DATA_W-SRC_N){1'b0}}, rawStat};
      default: rdata = '0;
    endcase
  end

  if (EN_TOP >= DATA_W) begin : g_bad_cfg
    initial $error("enable field does not fit the data word");
  end

endmodule

// File: rtl/spi_irq_top.sv
module spi_irq_top
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int EN_BASE = 4,
  parameter logic [ADDR_W-1:0] OFF_CTRL = 8'h00,
  parameter logic [ADDR_W-1:0] OFF_CLR  = 8'h0c,
  parameter logic [ADDR_W-1:0] OFF_MASK = 8'h20,
  parameter logic [ADDR_W-1:0] OFF_RAW  = 8'h24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              evtTxDone,
  input  logic              evtRxReady,
  input  logic              evtRxOverflow,
  input  logic              evtTxUnderrun,
  output logic              irq
);

  regStrobe_t       strb;
  logic [SRC_N-1:0] evtVec;
  logic [SRC_N-1:0] rawStat;
  logic [SRC_N-1:0] enStat;

  // status order: 0 tx done, 1 rx ready, 2 rx overflow, 3 tx underrun
  assign evtVec = {evtTxUnderrun, evtRxOverflow, evtRxReady, evtTxDone};

  spi_irq_ctrl #(
    .ADDR_W  (ADDR_W),
    .OFF_CTRL(OFF_CTRL),
    .OFF_CLR (OFF_CLR),
    .OFF_MASK(OFF_MASK),
    .OFF_RAW (OFF_RAW)
  ) u_ctrl (
    .busEn  (busEn),
    .busWe  (busWe),
    .busAddr(busAddr),
    .strb   (strb)
  );

  spi_irq_datapath #(
    .DATA_W (DATA_W),
    .EN_BASE(EN_BASE)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .wdata  (busWdata),
    .evtVec (evtVec),
    .rawStat(rawStat),
    .enStat (enStat),
    .rdata  (busRdata),
    .irq    (irq)
  );

endmodule

// File: rtl/spi_irq_chk.sv
module spi_irq_chk
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFF_CLR = 8'h0c
) (
  input logic              clk,
  input logic              rst,
  input logic              busEn,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [SRC_N-1:0]  evtVec,
  input logic [SRC_N-1:0]  rawStat,
  input logic              irq
);

  logic             clrHit;
  logic [SRC_N-1:0] clrBits;

  assign clrHit  = busEn && busWe && (busAddr == OFF_CLR);
  assign clrBits = clrHit ? busWdata[SRC_N-1:0] : '0;

  // R1
  reset_clean_chk: assert property (@(posedge clk)
    $fell(rst) |-> (rawStat == '0 && !irq));

  // R2
  event_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (evtVec != '0) |=> ((rawStat & $past(evtVec)) == $past(evtVec)));

  // R3
  clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
    (clrBits & ~evtVec) != '0 |=> ((rawStat & $past(clrBits & ~evtVec)) == '0));

  // R3
  no_spurious_drop_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(rawStat) & ~rawStat & ~$past(clrBits)) == '0));

  // R4
  event_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ((clrBits & evtVec) != '0) |=> ((rawStat & $past(clrBits & evtVec)) != '0));

  // R7
  irq_needs_raw_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (rawStat != '0));

endmodule

bind spi_irq_top spi_irq_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .OFF_CLR(OFF_CLR)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .busEn   (busEn),
  .busWe   (busWe),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .evtVec  (evtVec),
  .rawStat (rawStat),
  .irq     (irq)
);

// File: tb/tb_spi_irq_top.sv
`timescale 1ns/1ps
module tb_spi_irq_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busEn = 1'b0, busWe = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        evtTxDone = 0, evtRxReady = 0, evtRxOverflow = 0, evtTxUnderrun = 0;
  logic        irq;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 0;
  string curReq = "R1";

  // reference state: raw bits in status order, control word as written
  bit [3:0]  refRaw = '0;
  bit [31:0] refCtrl = '0;

  always #2 clk = ~clk;  // 250 MHz

  spi_irq_top dut (
    .clk(clk), .rst(rst), .busEn(busEn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .evtTxDone(evtTxDone), .evtRxReady(evtRxReady),
    .evtRxOverflow(evtRxOverflow), .evtTxUnderrun(evtTxUnderrun), .irq(irq)
  );

  function automatic bit [3:0] refMasked();
    bit [3:0] m;
    m[0] = refRaw[0] & refCtrl[5];
    m[1] = refRaw[1] & refCtrl[4];
    m[2] = refRaw[2] & refCtrl[6];
    m[3] = refRaw[3] & refCtrl[7];
    return m;
  endfunction

  function automatic bit [31:0] refRead(bit e, bit w, bit [7:0] a);
    if (!e || w) return 32'h0;
    case (a)
      8'h00:   return refCtrl;
      8'h20:   return {28'h0, refMasked()};
      8'h24:   return {28'h0, refRaw};
      default: return 32'h0;
    endcase
  endfunction

  task automatic compare();
    bit [31:0] expR;
    bit expI;
    expR = refRead(busEn, busWe, busAddr);
    expI = (refMasked() != 4'h0);
    testsRun++;
    if (busRdata !== expR || irq !== expI) begin
      testsFailed++;
      $display("FAIL %s addr=%h rdata=%h exp=%h irq=%b exp=%b",
               curReq, busAddr, busRdata, expR, irq, expI);
    end
  endtask

  // one cycle: drive at falling edge, compare, advance model at rising edge
  task automatic step(bit e, bit w, bit [7:0] a, bit [31:0] d, bit [3:0] ev);
    bit [3:0] nxt;
    busEn = e; busWe = w; busAddr = a; busWdata = d;
    {evtTxUnderrun, evtRxOverflow, evtRxReady, evtTxDone} = ev;
    #1;
    compare();
    @(posedge clk);
    nxt = refRaw;
    if (e && w && a == 8'h0c) nxt = nxt & ~d[3:0];
    nxt = nxt | ev;
    refRaw = nxt;
    if (e && w && a == 8'h00) refCtrl = d & 32'h0000_00f0;
    @(negedge clk);
  endtask

  task automatic rd(bit [7:0] a);
    step(1, 0, a, 32'h0, 4'h0);
  endtask

  task automatic wr(bit [7:0] a, bit [31:0] d);
    step(1, 1, a, d, 4'h0);
  endtask

  task automatic readAll();
    rd(8'h00); rd(8'h0c); rd(8'h20); rd(8'h24); rd(8'h10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    curReq = "R1";
    readAll();

    // R8: events latch with all enables off, irq stays low
    curReq = "R8";
    step(0, 0, 8'h00, 0, 4'b0101);
    rd(8'h24); rd(8'h20);

    // R2: each source alone, then read raw
    curReq = "R2";
    wr(8'h0c, 32'hf);
    for (int i = 0; i < 4; i++) begin
      step(1, 0, 8'h24, 0, 4'(1 << i));
      rd(8'h24);
      rd(8'h24);
      wr(8'h0c, 32'hf);
    end

    // R5: control mapping and readback of only bits 7:4
    curReq = "R5";
    wr(8'h00, 32'hffff_ffff); rd(8'h00);
    wr(8'h00, 32'h0000_0020); rd(8'h00);
    wr(8'h00, 32'h0000_0010); rd(8'h00);

    // R6, R7: masked view and irq per enable
    curReq = "R6";
    step(0, 0, 8'h00, 0, 4'hf);
    for (int i = 4; i < 8; i++) begin
      wr(8'h00, 32'(1 << i));
      rd(8'h20);
    end
    curReq = "R7";
    wr(8'h00, 32'h0); rd(8'h20);
    wr(8'h00, 32'h80); rd(8'h20);
    wr(8'h0c, 32'h8); rd(8'h20);

    // R3: clear patterns and zeros have no effect
    curReq = "R3";
    step(0, 0, 8'h00, 0, 4'hf);
    wr(8'h0c, 32'h0); rd(8'h24);
    wr(8'h0c, 32'h5); rd(8'h24);
    wr(8'h0c, 32'hffff_fff0); rd(8'h24);
    wr(8'h0c, 32'h2); rd(8'h24); rd(8'h0c);

    // R4: event and clear on the same bit at the same edge
    curReq = "R4";
    wr(8'h00, 32'hf0);
    step(1, 1, 8'h0c, 32'hf, 4'b1001);
    rd(8'h24); rd(8'h20);

    // R9: writes to read-only and undecoded offsets change nothing
    curReq = "R9";
    wr(8'h20, 32'h0); rd(8'h24);
    wr(8'h24, 32'hf); rd(8'h24);
    wr(8'h10, 32'hffff_ffff); rd(8'h00); rd(8'h10); rd(8'h0d); rd(8'h24);

    // R2: mixed random traffic against the model
    curReq = "R2";
    for (int n = 0; n < 3000; n++) begin
      bit [7:0] a;
      case ($urandom_range(0, 4))
        0: a = 8'h00; 1: a = 8'h0c; 2: a = 8'h20; 3: a = 8'h24; default: a = 8'h10;
      endcase
      step(1'($urandom), 1'($urandom), a, $urandom,
           ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired during %s", curReq);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule